// File: doc/BRIEF.md
# Rotational-Latency Disk Transfer Engine

This block moves a run of words between a head-per-track disk store and main memory. A controller loads a linear disk word address, a memory address and a two's-complement word count, picks the direction, and pulses start. The engine then waits for the requested word to rotate under the heads. It transfers words until the count reaches zero, and it raises a one-cycle done event when it stops.

The rotation is modelled by a free-running position counter. The counter advances by one word per interword interval and wraps at one track. Writes are refused on any track whose group of tracks has its lock switch set. A missing medium is reported as not-ready. Reads aimed at a memory address flagged invalid are dropped, but the transfer carries on. In burst mode the words follow on back-to-back cycles. Otherwise one word moves per interval. A cancel request halts a transfer at once, with no done event.

Top module: `hpt_xfer`

## Requirements
- R1: While reset is high, busy, done, ill_addr, not_ready, mem_we and disk_we are 0, and rot_pos and word_cnt are 0.
- R2: rot_pos advances by exactly 1 every max(ivl,1) cycles and wraps from TRK-1 to 0, where TRK = WPS*SPT words per track. An ivl of 0 behaves as 1.
- R3: The first word of a transfer is taken in a cycle in which rot_pos equals the disk address modulo TRK.
- R4: If media_ok is low when the first word is due, not_ready and done pulse together. Nothing is transferred and the disk address, memory address and word count keep their loaded values.
- R5: For a write word, the lock switch index is floor(disk address / (TRK*TPL)). If wlock at that index is 1, ill_addr and done pulse together, the word is not written, the counters do not advance, and the transfer ends.
- R6: For a read word whose mem_addr_ok is 0, nothing is written to memory, but all three counters still advance.
- R7: After each transferred word, word_cnt increases by 1 modulo 2^16, mem_addr increases by 1 modulo 2^MA_W, and disk_addr increases by 1, going from DISK-1 to 0.
- R8: In burst mode, the words of a transfer occupy consecutive cycles. Otherwise successive words are exactly max(ivl,1) cycles apart.
- R9: When the word count reaches 0, done pulses for one cycle and busy falls in the same cycle.
- R10: A cancel while busy drops busy on the next cycle, with no done and no further words. A cancel in the cycle in which a word is due suppresses that word.
- R11: A start pulse while busy changes neither the addresses nor the count of the running transfer.
- R12: A read word writes disk_rdata, taken from disk_addr, to mem_waddr, which equals the current memory address. A write word writes mem_rdata to disk_waddr, which equals the current disk address. mem_we and disk_we are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with the loaded values (ignored while busy) |
| cancel | input | 1 | Abort the running transfer without done |
| write_dir | input | 1 | 1 = memory to disk, 0 = disk to memory |
| burst | input | 1 | 1 = back-to-back words, 0 = one word per interval |
| start_da | input | DA_W | Starting linear disk word address |
| start_ma | input | MA_W | Starting memory address |
| start_wc | input | WC_W | Two's-complement word count (negative of the length) |
| ivl | input | IVL_W | Interword interval in cycles (0 treated as 1) |
| wlock | input | NLOCK | One write-lock switch per TPL tracks |
| media_ok | input | 1 | Medium present |
| disk_addr | output | DA_W | Current disk address, also the disk read address |
| disk_rdata | input | DW | Disk word at disk_addr |
| disk_we | output | 1 | Disk write strobe |
| disk_waddr | output | DA_W | Disk write address |
| disk_wdata | output | DW | Disk write data |
| mem_addr | output | MA_W | Current memory address, also the memory read address |
| mem_addr_ok | input | 1 | mem_addr lies in existing memory |
| mem_rdata | input | DW | Memory word at mem_addr |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | MA_W | Memory write address |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Transfer in progress |
| word_cnt | output | WC_W | Current word count |
| rot_pos | output | POS_W | Rotational word position within a track |
| done | output | 1 | One-cycle end-of-transfer event |
| ill_addr | output | 1 | One-cycle write-lock violation event |
| not_ready | output | 1 | One-cycle missing-medium event |

## Verification
A cancel request and a due word transfer can land in the same cycle. The cancel must win, so the word that would have moved is not moved. The bench provokes this both in burst mode, where a word is due every cycle, and in interval mode, where the cancel is raised right after a strobe is seen. It judges the result by counting the strobes observed before the cancel and requiring that the final word count has advanced by exactly that many. A start pulse that arrives during the seek of a running transfer is the second collision: the bench checks that the first transfer's data and end addresses are unchanged.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_XFER} hpt_state_e;
endpackage

// File: rtl/hpt_rotor.sv
// Free-running rotational position: one word per interword interval.
module hpt_rotor #(
  parameter int TRK   = 5120,
  parameter int IVL_W = 12,
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] ivl,
  output logic [POS_W-1:0] pos
);
  logic [IVL_W-1:0] cnt;
  logic [IVL_W-1:0] ivl_last;
  logic             tick;

  assign ivl_last = (ivl == '0) ? '0 : ivl - 1'b1;
  assign tick     = (cnt >= ivl_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pos <= '0;
    end else if (tick) begin
      cnt <= '0;
      pos <= (pos == POS_W'(TRK - 1)) ? '0 : pos + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hpt_lock_check.sv
// Maps a disk address to its lock group and reports whether writes are barred.
module hpt_lock_check #(
  parameter int DA_W      = 20,
  parameter int GRP_WORDS = 51200,
  parameter int NLOCK     = 20
) (
  input  logic [DA_W-1:0]  da,
  input  logic [NLOCK-1:0] wlock,
  output logic             locked
);
  localparam int IDX_W = (NLOCK > 1) ? $clog2(NLOCK) : 1;
  logic [DA_W-1:0] grp;

  assign grp = da / DA_W'(GRP_WORDS);

  generate
    if (NLOCK > 1) begin : g_multi
      assign locked = (grp < DA_W'(NLOCK)) ? wlock[grp[IDX_W-1:0]] : 1'b0;
    end else begin : g_single
      assign locked = (grp == '0) ? wlock[0] : 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hpt_xfer.sv
module hpt_xfer
  import hpt_pkg::*;
#(
  parameter int DW    = 18,
  parameter int WPS   = 64,
  parameter int SPT   = 80,
  parameter int NTRK  = 200,
  parameter int TPL   = 10,
  parameter int MA_W  = 15,
  parameter int IVL_W = 12,
  parameter int WC_W  = 16,
  localparam int TRK   = WPS * SPT,
  localparam int DISK  = TRK * NTRK,
  localparam int DA_W  = $clog2(DISK),
  localparam int POS_W = $clog2(TRK),
  localparam int NLOCK = NTRK / TPL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic             write_dir,
  input  logic             burst,
  input  logic [DA_W-1:0]  start_da,
  input  logic [MA_W-1:0]  start_ma,
  input  logic [WC_W-1:0]  start_wc,
  input  logic [IVL_W-1:0] ivl,
  input  logic [NLOCK-1:0] wlock,
  input  logic             media_ok,
  output logic [DA_W-1:0]  disk_addr,
  input  logic [DW-1:0]    disk_rdata,
  output logic             disk_we,
  output logic [DA_W-1:0]  disk_waddr,
  output logic [DW-1:0]    disk_wdata,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_addr_ok,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_we,
  output logic [MA_W-1:0]  mem_waddr,
  output logic [DW-1:0]    mem_wdata,
  output logic             busy,
  output logic [WC_W-1:0]  word_cnt,
  output logic [POS_W-1:0] rot_pos,
  output logic             done,
  output logic             ill_addr,
  output logic             not_ready
);
  hpt_state_e       st;
  logic [DA_W-1:0]  da;
  logic [MA_W-1:0]  ma;
  logic [WC_W-1:0]  wc;
  logic             wr_q, bst_q;
  logic [IVL_W-1:0] gap;

  logic [IVL_W-1:0] ivl_last;
  logic [POS_W-1:0] tgt;
  logic             due, locked;
  logic [WC_W-1:0]  wc_inc;
  logic [DA_W-1:0]  da_inc;

  hpt_rotor #(.TRK(TRK), .IVL_W(IVL_W), .POS_W(POS_W)) u_rotor (
    .clk(clk), .rst(rst), .ivl(ivl), .pos(rot_pos)
  );

  hpt_lock_check #(.DA_W(DA_W), .GRP_WORDS(TRK * TPL), .NLOCK(NLOCK)) u_lock (
    .da(da), .wlock(wlock), .locked(locked)
  );

  assign ivl_last = (ivl == '0) ? '0 : ivl - 1'b1;
  assign tgt      = POS_W'(da % DA_W'(TRK));
  assign due      = ((st == ST_SEEK) && (rot_pos == tgt)) ||
                    ((st == ST_XFER) && (gap == '0));
  assign wc_inc   = wc + 1'b1;
  assign da_inc   = (da == DA_W'(DISK - 1)) ? '0 : da + 1'b1;

  assign busy      = (st != ST_IDLE);
  assign disk_addr = da;
  assign mem_addr  = ma;
  assign word_cnt  = wc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      da         <= '0;
      ma         <= '0;
      wc         <= '0;
      wr_q       <= 1'b0;
      bst_q      <= 1'b0;
      gap        <= '0;
      disk_we    <= 1'b0;
      disk_waddr <= '0;
      disk_wdata <= '0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      ill_addr   <= 1'b0;
      not_ready  <= 1'b0;
    end else begin
      disk_we   <= 1'b0;
      mem_we    <= 1'b0;
      done      <= 1'b0;
      ill_addr  <= 1'b0;
      not_ready <= 1'b0;
      if (st == ST_IDLE) begin
        if (start && !cancel) begin
          da    <= start_da;
          ma    <= start_ma;
          wc    <= start_wc;
          wr_q  <= write_dir;
          bst_q <= burst;
          gap   <= '0;
          st    <= ST_SEEK;
        end
      end else if (cancel) begin
        st <= ST_IDLE;
      end else if (!due) begin
        if (st == ST_XFER) gap <= gap - 1'b1;
      end else if ((st == ST_SEEK) && !media_ok) begin
        not_ready <= 1'b1;
        done      <= 1'b1;
        st        <= ST_IDLE;
      end else if (wr_q && locked) begin
        ill_addr <= 1'b1;
        done     <= 1'b1;
        st       <= ST_IDLE;
      end else begin
        if (wr_q) begin
          disk_we    <= 1'b1;
          disk_waddr <= da;
          disk_wdata <= mem_rdata;
        end else if (mem_addr_ok) begin
          mem_we    <= 1'b1;
          mem_waddr <= ma;
          mem_wdata <= disk_rdata;
        end
        wc  <= wc_inc;
        ma  <= ma + 1'b1;
        da  <= da_inc;
        gap <= bst_q ? '0 : ivl_last;
        if (wc_inc == '0) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end else begin
          st <= ST_XFER;
        end
      end
    end
  end
endmodule

// File: rtl/hpt_xfer_chk.sv
module hpt_xfer_chk #(
  parameter int POS_W = 13,
  parameter int TRK   = 5120
) (
  input logic             clk,
  input logic             rst,
  input logic             cancel,
  input logic             busy,
  input logic             done,
  input logic             ill_addr,
  input logic             not_ready,
  input logic             mem_we,
  input logic             disk_we,
  input logic [POS_W-1:0] rot_pos
);
  // R9: done coincides with the fall of busy
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R4: not-ready is always reported with done
  a_r4_nr_with_done: assert property (@(posedge clk) disable iff (rst)
    not_ready |-> done);

  // R5: lock violation is always reported with done
  a_r5_ill_with_done: assert property (@(posedge clk) disable iff (rst)
    ill_addr |-> done);

  // R12: a word goes one way only
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && disk_we));

  // R12: strobes only follow an active transfer
  a_r12_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we || disk_we) |-> $past(busy));

  // R10: cancel ends the transfer quietly
  a_r10_cancel_stops: assert property (@(posedge clk) disable iff (rst)
    (busy && cancel) |=> (!busy && !done && !mem_we && !disk_we));

  // R2: position moves by one word, wrapping at the track end
  a_r2_rot_step: assert property (@(posedge clk) disable iff (rst)
    (rot_pos != $past(rot_pos)) |->
      (rot_pos == (($past(rot_pos) == POS_W'(TRK - 1)) ? '0 : $past(rot_pos) + 1'b1)));

  a_r2_rot_range: assert property (@(posedge clk) disable iff (rst)
    rot_pos < POS_W'(TRK));
endmodule

bind hpt_xfer hpt_xfer_chk #(.POS_W(POS_W), .TRK(TRK)) u_chk (
  .clk(clk), .rst(rst), .cancel(cancel), .busy(busy), .done(done),
  .ill_addr(ill_addr), .not_ready(not_ready), .mem_we(mem_we),
  .disk_we(disk_we), .rot_pos(rot_pos)
);

// File: tb/hpt_xfer_tb.sv
`timescale 1ns/1ps
module hpt_xfer_tb;
  localparam int DW = 18, WPS = 4, SPT = 5, NTRK = 8, TPL = 2;
  localparam int MA_W = 6, IVL_W = 4, WC_W = 16;
  localparam int TRK = WPS * SPT, DISK = TRK * NTRK, GRP = TRK * TPL;
  localparam int DA_W = $clog2(DISK), POS_W = $clog2(TRK), NLOCK = NTRK / TPL;
  localparam int MEMN = 1 << MA_W;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic start = 0, cancel = 0, write_dir = 0, burst = 0, media_ok = 1;
  logic [DA_W-1:0] start_da = '0;
  logic [MA_W-1:0] start_ma = '0;
  logic [WC_W-1:0] start_wc = '0;
  logic [IVL_W-1:0] ivl = 4'd1;
  logic [NLOCK-1:0] wlock = '0;
  logic [DA_W-1:0] disk_addr, disk_waddr;
  logic [DW-1:0] disk_rdata, disk_wdata, mem_rdata, mem_wdata;
  logic disk_we, mem_we, mem_addr_ok, busy, done, ill_addr, not_ready;
  logic [MA_W-1:0] mem_addr, mem_waddr;
  logic [WC_W-1:0] word_cnt;
  logic [POS_W-1:0] rot_pos;

  logic [DW-1:0] dsk [DISK];
  logic [DW-1:0] mem [MEMN];
  logic fill = 0;
  int mem_lim = MEMN;

  function automatic logic [DW-1:0] pd(int i); return DW'(18'h10000 + i * 3); endfunction
  function automatic logic [DW-1:0] pm(int i); return DW'(18'h20000 + i * 5); endfunction

  assign disk_rdata  = dsk[disk_addr];
  assign mem_rdata   = mem[mem_addr];
  assign mem_addr_ok = (int'(mem_addr) < mem_lim);

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < DISK; i++) dsk[i] <= pd(i);
      for (int i = 0; i < MEMN; i++) mem[i] <= pm(i);
    end else begin
      if (disk_we) dsk[disk_waddr] <= disk_wdata;
      if (mem_we) mem[mem_waddr] <= mem_wdata;
    end
  end

  hpt_xfer #(.DW(DW), .WPS(WPS), .SPT(SPT), .NTRK(NTRK), .TPL(TPL),
             .MA_W(MA_W), .IVL_W(IVL_W), .WC_W(WC_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cancel(cancel), .write_dir(write_dir),
    .burst(burst), .start_da(start_da), .start_ma(start_ma), .start_wc(start_wc),
    .ivl(ivl), .wlock(wlock), .media_ok(media_ok), .disk_addr(disk_addr),
    .disk_rdata(disk_rdata), .disk_we(disk_we), .disk_waddr(disk_waddr),
    .disk_wdata(disk_wdata), .mem_addr(mem_addr), .mem_addr_ok(mem_addr_ok),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy), .word_cnt(word_cnt), .rot_pos(rot_pos),
    .done(done), .ill_addr(ill_addr), .not_ready(not_ready));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_xfer = 0, n_done = 0, n_ill = 0, n_nr = 0;
  int first_pos = -1, last_cyc = 0, gmin = 999, gmax = 0, prev_pos = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (ill_addr) n_ill++;
    if (not_ready) n_nr++;
    if (mem_we || disk_we) begin
      if (n_xfer == 0) first_pos = prev_pos;
      else begin
        if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
        if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
      end
      last_cyc = cyc;
      n_xfer++;
    end
    prev_pos = int'(rot_pos);
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tk(); @(negedge clk); #1; endtask

  task automatic do_fill(); fill = 1; tk(); fill = 0; tk(); endtask

  function automatic logic [WC_W-1:0] negw(int n, int k); return WC_W'(65536 - n + k); endfunction

  task automatic launch(input int da0, input int ma0, input int n, input bit wr, input bit bst);
    start_da = DA_W'(da0); start_ma = MA_W'(ma0); start_wc = negw(n, 0);
    write_dir = wr; burst = bst;
    n_xfer = 0; n_done = 0; n_ill = 0; n_nr = 0; first_pos = -1; gmin = 999; gmax = 0;
    start = 1; tk(); start = 0;
  endtask

  task automatic finish_wait();
    int t = 0;
    while (busy && t < 3000) begin tk(); t++; end
    tk(); tk();
  endtask

  task automatic run(input int da0, input int ma0, input int n, input bit wr, input bit bst);
    launch(da0, ma0, n, wr, bst);
    finish_wait();
  endtask

  initial begin
    // R1 reset state
    repeat (3) tk();
    chk(!busy && !done && !ill_addr && !not_ready && !mem_we && !disk_we, "R1 flags", busy, 0);
    chk(rot_pos == 0 && word_cnt == 0, "R1 counters", rot_pos, 0);
    rst = 0;
    do_fill();

    // R2 rotation step and spacing, including wrap and ivl=0
    foreach (ivl_set[i]) ;
    for (int m = 0; m < 3; m++) begin
      int iv, eff, steps;
      iv = (m == 0) ? 3 : (m == 1) ? 0 : 1;
      eff = (iv == 0) ? 1 : iv;
      steps = (m == 2) ? 25 : 4;
      ivl = IVL_W'(iv);
      repeat (2 * 16) tk();
      for (int s = 0; s < steps; s++) begin
        int p, c;
        p = int'(rot_pos); c = 0;
        do begin tk(); c++; end while (int'(rot_pos) == p && c < 100);
        if (s > 0) chk(c == eff && int'(rot_pos) == (p + 1) % TRK, "R2 step", c, eff);
      end
    end

    // R3 R12 R7 R9: latency sweep, burst reads over every position of a track
    ivl = 4'd1;
    for (int o = 0; o < TRK; o++) begin
      run(3 * TRK + o, 0, 2, 0, 1);
      chk(first_pos == o, "R3 start pos", first_pos, o);
      chk(mem[0] == pd(3 * TRK + o) && mem[1] == pd(3 * TRK + o + 1), "R12 read data", mem[1], pd(3 * TRK + o + 1));
      chk(n_done == 1 && word_cnt == 0 && disk_addr == DA_W'(3 * TRK + o + 2), "R9 R7 end", disk_addr, 3 * TRK + o + 2);
      chk(gmin == 1 && gmax == 1, "R8 burst spacing", gmax, 1);
    end

    // R3 with a slower interval
    ivl = 4'd3;
    for (int o = 0; o < 4; o++) begin
      run(TRK + 5 * o, 8, 3, 0, 1);
      chk(first_pos == 5 * o, "R3 start pos ivl3", first_pos, 5 * o);
    end

    // R8 interval spacing: reads with ivl 3 and ivl 0
    for (int m = 0; m < 2; m++) begin
      int iv, eff;
      iv = (m == 0) ? 3 : 0; eff = (iv == 0) ? 1 : iv;
      ivl = IVL_W'(iv);
      do_fill();
      run(17, 4, 6, 0, 0);
      chk(n_xfer == 6 && gmin == eff && gmax == eff, "R8 interval spacing", gmax, eff);
      for (int k = 0; k < 6; k++) chk(mem[4 + k] == pd(17 + k), "R12 read run", mem[4 + k], pd(17 + k));
      chk(mem[10] == pm(10) && mem[3] == pm(3), "R12 neighbours", mem[10], pm(10));
    end

    // R12 write path, interval mode
    ivl = 4'd2; do_fill();
    run(5, 10, 6, 1, 0);
    for (int k = 0; k < 6; k++) chk(dsk[5 + k] == pm(10 + k), "R12 write run", dsk[5 + k], pm(10 + k));
    chk(dsk[4] == pd(4) && dsk[11] == pd(11), "R12 write neighbours", dsk[11], pd(11));
    chk(gmin == 2 && gmax == 2 && n_done == 1, "R8 write spacing", gmax, 2);

    // R5 write-lock per group
    ivl = 4'd1;
    for (int g = 0; g < NLOCK; g++) begin
      int b, w;
      do_fill();
      wlock = NLOCK'(1 << g);
      b = (g == 0) ? 0 : g * GRP - 2;
      w = (g == 0) ? 0 : 2;
      run(b, 10, 4, 1, 1);
      chk(n_ill == 1 && n_done == 1 && n_xfer == w, "R5 lock stop", n_xfer, w);
      chk(int'(disk_addr) == g * GRP && word_cnt == negw(4, w), "R5 counters held", disk_addr, g * GRP);
      chk(dsk[g * GRP] == pd(g * GRP), "R5 word not written", dsk[g * GRP], pd(g * GRP));
      if (g > 0) chk(dsk[b] == pm(10) && dsk[b + 1] == pm(11), "R5 words before lock", dsk[b + 1], pm(11));
    end
    wlock = '0;
    run(GRP - 2, 10, 4, 1, 1);
    chk(n_ill == 0 && n_xfer == 4, "R5 unlocked passes", n_xfer, 4);

    // R4 missing medium
    media_ok = 0;
    run(33, 7, 3, 0, 1);
    chk(n_nr == 1 && n_done == 1 && n_xfer == 0, "R4 not ready", n_nr, 1);
    chk(disk_addr == 33 && mem_addr == 7 && word_cnt == negw(3, 0), "R4 counters held", disk_addr, 33);
    media_ok = 1;

    // R6 invalid memory addresses on read
    do_fill(); mem_lim = 48;
    run(70, 46, 4, 0, 1);
    chk(mem[46] == pd(70) && mem[47] == pd(71), "R6 valid part", mem[47], pd(71));
    chk(mem[48] == pm(48) && mem[49] == pm(49), "R6 dropped words", mem[48], pm(48));
    chk(mem_addr == 50 && disk_addr == 74 && word_cnt == 0 && n_xfer == 2, "R6 counters advance", mem_addr, 50);
    mem_lim = MEMN;

    // R7 disk and memory wrap
    do_fill();
    run(DISK - 2, MEMN - 2, 4, 0, 1);
    chk(mem[MEMN - 2] == pd(DISK - 2) && mem[0] == pd(0) && mem[1] == pd(1), "R7 wrap data", mem[0], pd(0));
    chk(disk_addr == 2 && mem_addr == 2 && word_cnt == 0, "R7 wrap end", disk_addr, 2);

    // R11 start while busy
    ivl = 4'd4; do_fill();
    launch(60, 0, 3, 0, 0);
    start_da = DA_W'(100); start_ma = MA_W'(20); start_wc = negw(5, 0);
    chk(busy, "R11 busy before restart", busy, 1);
    start = 1; tk(); start = 0;
    finish_wait();
    chk(n_xfer == 3 && mem[2] == pd(62) && mem[20] == pm(20), "R11 ignored", n_xfer, 3);
    chk(disk_addr == 63 && mem_addr == 3, "R11 addresses", disk_addr, 63);

    // R10 cancel in interval mode, right after a strobe
    do_fill();
    launch(40, 0, 10, 0, 0);
    while (n_xfer < 3 && busy) tk();
    cancel = 1; tk(); cancel = 0;
    repeat (40) tk();
    chk(n_xfer == 3 && n_done == 0 && !busy, "R10 interval cancel", n_xfer, 3);
    chk(word_cnt == negw(10, 3), "R10 count", word_cnt, negw(10, 3));

    // R10 cancel while a word is due every cycle
    ivl = 4'd1;
    begin
      int c;
      launch(80, 0, 40, 0, 1);
      while (n_xfer < 2 && busy) tk();
      c = n_xfer;
      cancel = 1; tk(); cancel = 0;
      repeat (20) tk();
      chk(n_xfer == c && n_done == 0 && !busy, "R10 burst cancel", n_xfer, c);
      chk(word_cnt == negw(40, c), "R10 burst count", word_cnt, negw(40, c));
    end

    summary();
  end

  int ivl_set [1];
endmodule